// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire serial slave engine in a small byte-wide nonvolatile store. While a write command is being received it gathers the data bytes into a page buffer. The buffer holds sixteen slots, and each slot has its own valid flag. The in-page pointer starts at the low bits of the word address that the command carries. It steps by one per byte and wraps inside the page, so a burst longer than a page overwrites its own earlier bytes.

Nothing reaches the array unless the command is closed by a STOP. A repeated START abandons the collected data, and so does a STOP that arrives with no data byte or while the supply-low inhibit is raised.

A valid STOP opens a timed internal write window of `WR_CYCLES` clocks, during which `busy_o` is high. In the first `PAGE_BYTES` clocks of the window the controller walks the slots in ascending order and writes each valid slot to the array, one per clock. `done_o` pulses once when the window expires. An abort request from the protect logic ends the window at once. It replaces the byte being copied in that clock with a poison value to mark it as undefined, and it suppresses every later write and the done pulse.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `arr_we_o` are low.
- R2: Each data byte is written at the address whose upper bits come from the word address that `wr_begin_i` presented and whose low four bits come from an in-page pointer. The pointer starts at the low four bits of that address and advances by one per byte, modulo 16.
- R3: When more than 16 bytes arrive before STOP, a later byte replaces the earlier byte in the same slot, and only the last value is written.
- R4: Only slots that received a byte are written, so a single-byte command changes exactly one array location.
- R5: A write begins only at `stop_i`: `busy_o` rises in the clock after the STOP is sampled. A `start_i` during collection discards the buffer, and no array write follows it.
- R6: A command that delivers no data byte before STOP writes nothing, and `busy_o` stays low.
- R7: `busy_o` stays high for exactly `WR_CYCLES` clocks. In busy clock k (k below 16), slot k is written if it is valid, and no array write occurs outside busy.
- R8: On normal completion, `done_o` is high for one clock, in the clock right after the last busy clock.
- R9: `abort_i` during busy drops `busy_o` in the next clock, and `done_o` does not pulse. If the abort clock falls in the copy phase on a valid slot, that slot is written with `POISON`. No later write happens.
- R10: A STOP sampled while `supply_low_i` is high starts no write, and `busy_o` stays low.
- R11: While busy, `wr_begin_i`, `byte_vld_i`, `stop_i` and `start_i` have no effect, and no write follows from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin_i | input | 1 | Strobe: write command opened, word address valid |
| wr_addr_i | input | ADDR_W | Word address of the write command |
| byte_vld_i | input | 1 | Strobe: one data byte received |
| byte_data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | STOP condition seen on the bus |
| start_i | input | 1 | START condition seen on the bus |
| abort_i | input | 1 | Abort request from the protect logic |
| supply_low_i | input | 1 | Low-supply write inhibit |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Internal write window active |
| done_o | output | 1 | One-clock pulse at normal completion |

## Verification
The hardest state to reach is an abort that lands in a chosen clock of the copy phase on a slot known to be valid. Only that case shows the poison write, and only that case shows that the copy is cut off part way through the page. The stimulus closes an eight-byte page with a STOP, counts clocks from the STOP strobe, and raises the abort three clocks into the window. A second abort is placed deep in the waiting phase to show that an early completion is withheld. A behavioural model predicts every output in every clock, so the exact clock in which each write and the busy fall occur is checked.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   typedef enum logic [1:0] {
      PC_IDLE   = 2'd0,
      PC_FILL   = 2'd1,
      PC_COMMIT = 2'd2
   } pc_state_e;
endpackage

// File: rtl/pcc_page_buffer.sv
module pcc_page_buffer #(
   parameter int SLOTS  = 16,
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic [IDX_W-1:0]  open_ptr_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              any_valid_o
);
   logic [IDX_W-1:0]  wr_ptr_q;
   logic [DATA_W-1:0] slot_data_q [SLOTS];
   logic [SLOTS-1:0]  slot_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_ptr_q <= '0;
      else if (open_i)
         wr_ptr_q <= open_ptr_i;
      else if (push_i)
         wr_ptr_q <= wr_ptr_q + 1'b1;
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_vld_q[g]  <= 1'b0;
            slot_data_q[g] <= '0;
         end else if (open_i) begin
            slot_vld_q[g]  <= 1'b0;
         end else if (push_i && (wr_ptr_q == IDX_W'(g))) begin
            slot_vld_q[g]  <= 1'b1;
            slot_data_q[g] <= push_data_i;
         end
      end
   end

   assign rd_data_o   = slot_data_q[rd_idx_i];
   assign rd_valid_o  = slot_vld_q[rd_idx_i];
   assign any_valid_o = |slot_vld_q;
endmodule

// File: rtl/pcc_commit_timer.sv
module pcc_commit_timer #(
   parameter int CYCLES = 64,
   parameter int CNT_W  = $clog2(CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || (cnt_q == LAST_VAL))
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign last_o = run_i && (cnt_q == LAST_VAL);

   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= LAST_VAL));

   // R7
   cnt_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !$past(run_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
   parameter int                ADDR_W       = 8,
   parameter int                DATA_W       = 8,
   parameter int                PAGE_BYTES   = 16,
   parameter int                WR_CYCLES    = 64,
   parameter bit                ABORT_POISON = 1'b1,
   parameter logic [DATA_W-1:0] POISON       = DATA_W'('h5A)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_begin_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              stop_i,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              supply_low_i,
   output logic              arr_we_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic [DATA_W-1:0] arr_wdata_o,
   output logic              busy_o,
   output logic              done_o
);
   import pcc_pkg::*;

   localparam int IDX_W = $clog2(PAGE_BYTES);
   localparam int HI_W  = ADDR_W - IDX_W;
   localparam int CNT_W = $clog2(WR_CYCLES);

   if (PAGE_BYTES != (1 << IDX_W)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (WR_CYCLES <= PAGE_BYTES) begin : g_bad_time
      $error("WR_CYCLES must exceed PAGE_BYTES");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the in-page index width");
   end

   pc_state_e         state_q, state_d;
   logic [HI_W-1:0]   page_q;
   logic              done_q;
   logic              open_s, push_s;
   logic [CNT_W-1:0]  cnt_s;
   logic              last_s;
   logic [IDX_W-1:0]  rd_idx_s;
   logic [DATA_W-1:0] rd_data_s;
   logic              rd_valid_s, any_valid_s;
   logic              committing_s, in_copy_s;

   pcc_page_buffer #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .open_i      (open_s),
      .open_ptr_i  (wr_addr_i[IDX_W-1:0]),
      .push_i      (push_s),
      .push_data_i (byte_data_i),
      .rd_idx_i    (rd_idx_s),
      .rd_data_o   (rd_data_s),
      .rd_valid_o  (rd_valid_s),
      .any_valid_o (any_valid_s)
   );

   pcc_commit_timer #(.CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (committing_s),
      .cnt_o  (cnt_s),
      .last_o (last_s)
   );

   always_comb begin
      state_d = state_q;
      open_s  = 1'b0;
      push_s  = 1'b0;
      unique case (state_q)
         PC_IDLE: begin
            if (wr_begin_i) begin
               open_s  = 1'b1;
               state_d = PC_FILL;
            end
         end
         PC_FILL: begin
            if (start_i)
               state_d = PC_IDLE;
            else if (stop_i)
               state_d = (any_valid_s && !supply_low_i) ? PC_COMMIT : PC_IDLE;
            else if (wr_begin_i)
               open_s = 1'b1;
            else if (byte_vld_i)
               push_s = 1'b1;
         end
         PC_COMMIT: begin
            if (abort_i || last_s)
               state_d = PC_IDLE;
         end
         default: state_d = PC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PC_IDLE;
         page_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= committing_s && last_s && !abort_i;
         if (open_s)
            page_q <= wr_addr_i[ADDR_W-1:IDX_W];
      end
   end

   assign committing_s = (state_q == PC_COMMIT);
   assign in_copy_s    = committing_s && (int'(cnt_s) < PAGE_BYTES);
   assign rd_idx_s     = cnt_s[IDX_W-1:0];
   assign arr_addr_o   = {page_q, rd_idx_s};
   assign busy_o       = committing_s;
   assign done_o       = done_q;

   if (ABORT_POISON) begin : g_poison
      assign arr_we_o    = in_copy_s && rd_valid_s;
      assign arr_wdata_o = abort_i ? POISON : rd_data_s;
   end else begin : g_drop
      assign arr_we_o    = in_copy_s && rd_valid_s && !abort_i;
      assign arr_wdata_o = rd_data_s;
   end

   // R7
   we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we_o |-> busy_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R9
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && abort_i) |=> (!busy_o && !done_o));

   // R10
   low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PC_FILL && stop_i && supply_low_i) |=> !busy_o);

   // R6
   empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PC_FILL && stop_i && !any_valid_s) |=> !busy_o);

   // R5
   busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));
endmodule

// File: tb/tb_page_commit_ctrl.sv
module tb_page_commit_ctrl;
   localparam int         CLK_PERIOD = 10;
   localparam int         WRC        = 40;
   localparam logic [7:0] POIS       = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_begin = 0, byte_vld = 0, stop_e = 0, start_e = 0, abort_r = 0, slow = 0;
   logic [7:0] wr_addr = 0, byte_data = 0;
   logic       arr_we, busy, done;
   logic [7:0] arr_addr, arr_wdata;

   int nchk = 0, nerr = 0;
   bit ended = 0;

   int mst = 0, mpage = 0, mptr = 0, mcnt = 0;
   logic [7:0] mbyte [16];
   bit  mval [16];
   bit  mdone = 0;
   logic [7:0] dut_img [256];
   logic [7:0] exp_img [256];
   bit saw_busy = 0, saw_done = 0;

   page_commit_ctrl #(.WR_CYCLES(WRC), .POISON(POIS)) dut (
      .clk(clk), .rst_n(rst_n), .wr_begin_i(wr_begin), .wr_addr_i(wr_addr),
      .byte_vld_i(byte_vld), .byte_data_i(byte_data), .stop_i(stop_e),
      .start_i(start_e), .abort_i(abort_r), .supply_low_i(slow),
      .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
      .busy_o(busy), .done_o(done));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   // per-clock reference model, compared before each rising edge
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         bit         e_busy, e_we;
         logic [7:0] e_addr, e_data;
         bit         anyv;
         e_busy = (mst == 2);
         e_we   = e_busy && (mcnt < 16) && mval[mcnt];
         e_addr = 8'((mpage << 4) | (mcnt & 15));
         e_data = abort_r ? POIS : mbyte[mcnt & 15];
         chk(busy == e_busy, "R7", "busy", busy, e_busy);
         chk(done == mdone, "R8", "done", done, mdone);
         chk(arr_we == e_we, "R5", "arr_we", arr_we, e_we);
         if (e_we && arr_we) begin
            chk(arr_addr == e_addr, "R2", "arr_addr", arr_addr, e_addr);
            chk(arr_wdata == e_data, "R9", "arr_wdata", arr_wdata, e_data);
         end
         if (arr_we) dut_img[arr_addr] = arr_wdata;
         if (e_we) exp_img[e_addr] = e_data;
         if (busy) saw_busy = 1;
         if (done) saw_done = 1;
         // advance model with the inputs the coming edge samples
         mdone = (mst == 2) && !abort_r && (mcnt == WRC - 1);
         anyv = 0;
         for (int i = 0; i < 16; i++) anyv |= mval[i];
         case (mst)
            0: if (wr_begin) begin
                  mpage = wr_addr >> 4; mptr = wr_addr & 15;
                  for (int i = 0; i < 16; i++) mval[i] = 0;
                  mst = 1;
               end
            1: if (start_e) mst = 0;
               else if (stop_e) begin
                  if (anyv && !slow) begin mst = 2; mcnt = 0; end
                  else mst = 0;
               end else if (wr_begin) begin
                  mpage = wr_addr >> 4; mptr = wr_addr & 15;
                  for (int i = 0; i < 16; i++) mval[i] = 0;
               end else if (byte_vld) begin
                  mbyte[mptr] = byte_data; mval[mptr] = 1;
                  mptr = (mptr + 1) % 16;
               end
            default: if (abort_r || mcnt == WRC - 1) mst = 0;
                     else mcnt++;
         endcase
      end
   end

   task automatic drv(input logic wb, input logic [7:0] a, input logic bv, input logic [7:0] d,
                      input logic sp, input logic st, input logic ab, input logic sl);
      @(posedge clk); #1;
      wr_begin = wb; wr_addr = a; byte_vld = bv; byte_data = d;
      stop_e = sp; start_e = st; abort_r = ab; slow = sl;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic send(input logic [7:0] a, input int n, input logic [7:0] d0);
      drv(1, a, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < n; i++) drv(0, 0, 1, 8'(d0 + i), 0, 0, 0, 0);
      drv(0, 0, 0, 0, 1, 0, 0, 0);
      drv(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic settle();
      do @(posedge clk); while (busy || mst != 0);
      idle(3);
   endtask

   task automatic img(input logic [7:0] a, input logic [7:0] e, input string req);
      chk(dut_img[a] === e, req, "array byte", dut_img[a], e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL R7 watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) begin dut_img[i] = 8'hFF; exp_img[i] = 8'hFF; end
      for (int i = 0; i < 16; i++) begin mbyte[i] = 0; mval[i] = 0; end
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(busy == 0, "R1", "busy after reset", busy, 0);
      chk(done == 0, "R1", "done after reset", done, 0);
      chk(arr_we == 0, "R1", "arr_we after reset", arr_we, 0);
      rst_n = 1;
      idle(2);

      // R2 plain page write and in-page wrap
      send(8'h35, 4, 8'h10); settle();
      img(8'h35, 8'h10, "R2"); img(8'h38, 8'h13, "R2"); img(8'h39, 8'hFF, "R2");
      send(8'h3E, 4, 8'hA0); settle();
      img(8'h3E, 8'hA0, "R2"); img(8'h3F, 8'hA1, "R2"); img(8'h30, 8'hA2, "R2"); img(8'h31, 8'hA3, "R2");
      img(8'h40, 8'hFF, "R2");

      // R3 overlong burst
      send(8'h50, 20, 8'h80); settle();
      img(8'h50, 8'h90, "R3"); img(8'h53, 8'h93, "R3"); img(8'h54, 8'h84, "R3"); img(8'h5F, 8'h8F, "R3");

      // R4 single byte
      send(8'h77, 1, 8'hC3); settle();
      img(8'h77, 8'hC3, "R4"); img(8'h76, 8'hFF, "R4"); img(8'h78, 8'hFF, "R4");

      // R5 repeated START discards
      saw_busy = 0;
      drv(1, 8'h90, 0, 0, 0, 0, 0, 0);
      drv(0, 0, 1, 8'h01, 0, 0, 0, 0);
      drv(0, 0, 1, 8'h02, 0, 0, 0, 0);
      drv(0, 0, 0, 0, 0, 1, 0, 0);
      drv(0, 0, 0, 0, 1, 0, 0, 0);
      idle(5);
      chk(saw_busy == 0, "R5", "busy after START cancel", saw_busy, 0);
      img(8'h90, 8'hFF, "R5");

      // R6 no data bytes
      saw_busy = 0;
      send(8'hA0, 0, 8'h00); idle(5);
      chk(saw_busy == 0, "R6", "busy on empty command", saw_busy, 0);
      img(8'hA0, 8'hFF, "R6");

      // R8 done after normal write
      saw_done = 0;
      send(8'h08, 2, 8'h33); settle();
      chk(saw_done == 1, "R8", "done seen", saw_done, 1);

      // R9 abort in copy phase at busy clock 3
      saw_done = 0;
      send(8'hB0, 8, 8'h20);
      idle(2);
      drv(0, 0, 0, 0, 0, 0, 1, 0);
      idle(1);
      settle();
      img(8'hB0, 8'h20, "R9"); img(8'hB2, 8'h22, "R9"); img(8'hB3, POIS, "R9"); img(8'hB4, 8'hFF, "R9");
      chk(saw_done == 0, "R9", "done after abort", saw_done, 0);

      // R9 abort in waiting phase
      send(8'hB8, 2, 8'h40);
      idle(20);
      drv(0, 0, 0, 0, 0, 0, 1, 0);
      idle(1);
      settle();
      img(8'hB9, 8'h41, "R9");
      chk(saw_done == 0, "R9", "done after late abort", saw_done, 0);

      // R10 supply low at STOP
      saw_busy = 0;
      drv(1, 8'hE0, 0, 0, 0, 0, 0, 0);
      drv(0, 0, 1, 8'h11, 0, 0, 0, 0);
      drv(0, 0, 0, 0, 1, 0, 0, 1);
      idle(5);
      chk(saw_busy == 0, "R10", "busy with supply low", saw_busy, 0);
      img(8'hE0, 8'hFF, "R10");

      // R11 commands during busy ignored
      send(8'hC0, 1, 8'h66);
      drv(1, 8'hD0, 0, 0, 0, 0, 0, 0);
      drv(0, 0, 1, 8'h77, 0, 0, 0, 0);
      drv(0, 0, 0, 0, 1, 0, 0, 0);
      idle(1);
      settle();
      saw_busy = 0;
      idle(5);
      img(8'hC0, 8'h66, "R11"); img(8'hD0, 8'hFF, "R11");
      chk(saw_busy == 0, "R11", "busy after ignored command", saw_busy, 0);

      // full image against model
      for (int i = 0; i < 256; i++)
         chk(dut_img[i] === exp_img[i], "R4", "image", dut_img[i], exp_img[i]);

      finish_run();
   end
endmodule